// File: doc/BRIEF.md
# Bit-Band Alias Remapper

This block sits between one bus master and the downstream memory and peripheral bus. Each aliased region is a large window of word addresses in which every word stands for a single bit of a real target word. A master can therefore set, clear or test one bit of a register or memory word with a single access.

When a word-sized write lands in an alias window, the block reads the target word and writes it back with only the selected bit changed. The bit's new value is bit 0 of the write data. The read and the write are issued back to back, and a lock output stays high from the first request until the last response, so nothing else can touch the word in between. A word-sized read in an alias window reads the target word and returns the selected bit in bit 0. Any access outside the alias windows is forwarded unchanged.

The default configuration has two region pairs: targets at 0x4000_0000 and 0x2000_0000, with alias windows at 0x4200_0000 and 0x2200_0000. Each alias window spans 32 MB. Both upstream and downstream use a request channel with valid/ready and a response channel with a single-cycle valid pulse. Only one transaction is outstanding at a time.

Top module: `bb_remap`

## Requirements
- R1: An access outside every alias window is forwarded with the same address, write data, write flag and size, with the lock low. Its downstream read data and error are returned upstream unchanged.
- R2: An alias address A in a window with alias base AB and target base TB selects bit index `{A[6:5], A[4:2]}` of the target word `(TB + A[24:5]) & ~3`. For example, 0x4240_0380 selects bit 0 of the word at 0x4002_001C.
- R3: A word-sized alias write changes only the selected bit of the target word. The bit becomes write-data bit 0, and write-data bits 31..1 have no effect.
- R4: A word-sized alias write produces exactly two downstream requests to the target word: first a word read, then a word write. The lock is high on both requests.
- R5: A word-sized alias read produces one unlocked downstream word read. It returns 0x0000_0001 if the selected bit is set and 0x0000_0000 if it is clear.
- R6: A byte-size (size 0) or halfword-size (size 1) access to an alias address returns an error, issues no downstream request and leaves the target word unchanged. Size 2 means word.
- R7: If the read half of an alias write returns an error, the error is passed upstream and no write is issued.
- R8: If the write half of an alias write returns an error, the error is passed upstream.
- R9: After reset, the request ready output is high, and neither downstream request valid nor response valid is asserted. Ready stays low from acceptance until the single-cycle response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Block can accept a request |
| up_addr | input | 32 | Master byte address |
| up_wdata | input | 32 | Master write data |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_rsp_valid | output | 1 | Response pulse |
| up_rdata | output | 32 | Response read data |
| up_rsp_err | output | 1 | Response error |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts request |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_write | output | 1 | Downstream write flag |
| dn_size | output | 2 | Downstream access size |
| dn_lock | output | 1 | High across both halves of a read-modify-write |
| dn_rsp_valid | input | 1 | Downstream response pulse |
| dn_rdata | input | 32 | Downstream read data |
| dn_err | input | 1 | Downstream error |

## Verification
The bench builds the block with its default parameters: two region pairs at the standard bases and a 25-bit alias span. With these settings the worked example address can be used directly. The sweep walks every bit of four target words in both regions. Each bit is written through its alias with varying upper write-data bits and then read back. This covers all 32 bit indices, including those chosen by the byte-offset bits. The downstream model stalls its ready signal periodically, and errors can be injected on chosen words for either half of a read-modify-write.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BB_AW    = 32;
    localparam int BB_DW    = 32;
    localparam int BB_BIT_W = $clog2(BB_DW);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } bb_state_e;

    typedef enum logic [1:0] {
        OP_PASS,
        OP_AREAD,
        OP_RMW_RD,
        OP_RMW_WR
    } bb_op_e;

    typedef struct packed {
        logic                hit;
        logic [BB_AW-1:0]    word_addr;
        logic [BB_BIT_W-1:0] bit_idx;
    } bb_map_t;

    function automatic logic [BB_DW-1:0] bb_put_bit(
        input logic [BB_DW-1:0]    w,
        input logic [BB_BIT_W-1:0] idx,
        input logic                v
    );
        logic [BB_DW-1:0] r;
        r      = w;
        r[idx] = v;
        return r;
    endfunction

endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
    import bb_pkg::*;
#(
    parameter int                   NREG         = 2,
    parameter logic [NREG*32-1:0]   TGT_BASES    = {32'h2000_0000, 32'h4000_0000},
    parameter logic [NREG*32-1:0]   ALIAS_BASES  = {32'h2200_0000, 32'h4200_0000},
    parameter int                   ALIAS_SPAN_W = 25
) (
    input  logic [BB_AW-1:0] addr,
    output bb_map_t          map
);
    localparam int OFF_W = ALIAS_SPAN_W - 5;

    logic [NREG-1:0]  hit_v;
    logic [BB_AW-1:0] tgt_v [NREG];
    logic [BB_AW-1:0] tgt_byte;
    logic             unused_lo;

    assign unused_lo = ^addr[1:0];

    for (genvar r = 0; r < NREG; r++) begin : g_region
        localparam logic [31:0] TB = TGT_BASES[r*32 +: 32];
        localparam logic [31:0] AB = ALIAS_BASES[r*32 +: 32];
        assign hit_v[r] = (addr[BB_AW-1:ALIAS_SPAN_W] == AB[BB_AW-1:ALIAS_SPAN_W]);
        assign tgt_v[r] = TB + {{(BB_AW-OFF_W){1'b0}}, addr[ALIAS_SPAN_W-1:5]};
    end

    always_comb begin
        tgt_byte = '0;
        map      = '0;
        for (int r = NREG - 1; r >= 0; r--) begin
            if (hit_v[r]) begin
                map.hit  = 1'b1;
                tgt_byte = tgt_v[r];
            end
        end
        map.word_addr = {tgt_byte[BB_AW-1:2], 2'b00};
        map.bit_idx   = {addr[6:5], addr[4:2]};
    end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [BB_DW-1:0]    old_word,
    input  logic [BB_BIT_W-1:0] bit_idx,
    input  logic                set_val,
    output logic [BB_DW-1:0]    new_word,
    output logic                bit_out
);
    always_comb begin
        new_word = bb_put_bit(old_word, bit_idx, set_val);
        bit_out  = old_word[bit_idx];
    end

    // R3
    single_bit_delta_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(old_word ^ new_word) <= 1);

endmodule

// File: rtl/bb_remap.sv
module bb_remap
    import bb_pkg::*;
#(
    parameter int                 NREG         = 2,
    parameter logic [NREG*32-1:0] TGT_BASES    = {32'h2000_0000, 32'h4000_0000},
    parameter logic [NREG*32-1:0] ALIAS_BASES  = {32'h2200_0000, 32'h4200_0000},
    parameter int                 ALIAS_SPAN_W = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        up_req_valid,
    output logic        up_req_ready,
    input  logic [31:0] up_addr,
    input  logic [31:0] up_wdata,
    input  logic        up_write,
    input  logic [1:0]  up_size,
    output logic        up_rsp_valid,
    output logic [31:0] up_rdata,
    output logic        up_rsp_err,
    output logic        dn_req_valid,
    input  logic        dn_req_ready,
    output logic [31:0] dn_addr,
    output logic [31:0] dn_wdata,
    output logic        dn_write,
    output logic [1:0]  dn_size,
    output logic        dn_lock,
    input  logic        dn_rsp_valid,
    input  logic [31:0] dn_rdata,
    input  logic        dn_err
);
    bb_state_e           state_q;
    bb_op_e              op_q;
    logic [BB_AW-1:0]    addr_q;
    logic [BB_DW-1:0]    wdata_q;
    logic                write_q;
    logic [1:0]          size_q;
    logic [BB_BIT_W-1:0] bit_q;
    logic                setv_q;
    logic [BB_DW-1:0]    rsp_data_q;
    logic                rsp_err_q;

    bb_map_t             map;
    logic [BB_DW-1:0]    merged;
    logic                sel_bit;
    logic                accept;

    bb_alias_decode #(
        .NREG         (NREG),
        .TGT_BASES    (TGT_BASES),
        .ALIAS_BASES  (ALIAS_BASES),
        .ALIAS_SPAN_W (ALIAS_SPAN_W)
    ) u_decode (
        .addr (up_addr),
        .map  (map)
    );

    bb_bit_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .old_word (dn_rdata),
        .bit_idx  (bit_q),
        .set_val  (setv_q),
        .new_word (merged),
        .bit_out  (sel_bit)
    );

    assign accept = up_req_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_PASS;
            addr_q     <= '0;
            wdata_q    <= '0;
            write_q    <= 1'b0;
            size_q     <= SZ_WORD;
            bit_q      <= '0;
            setv_q     <= 1'b0;
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!map.hit) begin
                            op_q    <= OP_PASS;
                            addr_q  <= up_addr;
                            wdata_q <= up_wdata;
                            write_q <= up_write;
                            size_q  <= up_size;
                            state_q <= ST_ISSUE;
                        end else if (up_size != SZ_WORD) begin
                            rsp_data_q <= '0;
                            rsp_err_q  <= 1'b1;
                            state_q    <= ST_RESP;
                        end else begin
                            op_q    <= up_write ? OP_RMW_RD : OP_AREAD;
                            addr_q  <= map.word_addr;
                            bit_q   <= map.bit_idx;
                            setv_q  <= up_wdata[0];
                            wdata_q <= '0;
                            write_q <= 1'b0;
                            size_q  <= SZ_WORD;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (dn_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (dn_rsp_valid) begin
                        unique case (op_q)
                            OP_PASS: begin
                                rsp_data_q <= dn_rdata;
                                rsp_err_q  <= dn_err;
                                state_q    <= ST_RESP;
                            end
                            OP_AREAD: begin
                                rsp_data_q <= {{(BB_DW-1){1'b0}}, sel_bit};
                                rsp_err_q  <= dn_err;
                                state_q    <= ST_RESP;
                            end
                            OP_RMW_RD: begin
                                if (dn_err) begin
                                    rsp_data_q <= '0;
                                    rsp_err_q  <= 1'b1;
                                    state_q    <= ST_RESP;
                                end else begin
                                    wdata_q <= merged;
                                    write_q <= 1'b1;
                                    op_q    <= OP_RMW_WR;
                                    state_q <= ST_ISSUE;
                                end
                            end
                            OP_RMW_WR: begin
                                rsp_data_q <= '0;
                                rsp_err_q  <= dn_err;
                                state_q    <= ST_RESP;
                            end
                        endcase
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
            endcase
        end
    end

    assign up_req_ready = (state_q == ST_IDLE);
    assign up_rsp_valid = (state_q == ST_RESP);
    assign up_rdata     = rsp_data_q;
    assign up_rsp_err   = rsp_err_q;
    assign dn_req_valid = (state_q == ST_ISSUE);
    assign dn_addr      = addr_q;
    assign dn_wdata     = wdata_q;
    assign dn_write     = write_q;
    assign dn_size      = size_q;
    assign dn_lock      = ((op_q == OP_RMW_RD) || (op_q == OP_RMW_WR)) &&
                          ((state_q == ST_ISSUE) || (state_q == ST_WAIT));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        up_rsp_valid |=> !up_rsp_valid);

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (up_rsp_valid || dn_req_valid) |-> !up_req_ready);

    // R4
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dn_lock) |-> $past(dn_rsp_valid));

    // R6
    narrow_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && map.hit && up_size != SZ_WORD) |=>
            (up_rsp_valid && up_rsp_err && !dn_req_valid));

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req_valid && !dn_req_ready) |=>
            (dn_req_valid && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_write)));

endmodule

// File: tb/bb_remap_test.sv
module bb_remap_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_req_valid = 1'b0;
    logic        up_req_ready;
    logic [31:0] up_addr = '0;
    logic [31:0] up_wdata = '0;
    logic        up_write = 1'b0;
    logic [1:0]  up_size = 2'd2;
    logic        up_rsp_valid;
    logic [31:0] up_rdata;
    logic        up_rsp_err;
    logic        dn_req_valid;
    logic        dn_req_ready = 1'b0;
    logic [31:0] dn_addr;
    logic [31:0] dn_wdata;
    logic        dn_write;
    logic [1:0]  dn_size;
    logic        dn_lock;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rdata = '0;
    logic        dn_err = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [31:0] mem     [32];
    logic [31:0] exp_mem [32];
    int          err_rd_idx = -1;
    int          err_wr_idx = -1;
    int          hs_cnt = 0;
    logic        hs_lock  [4];
    logic        hs_write [4];
    logic [31:0] hs_addr  [4];
    logic [1:0]  hs_size  [4];
    logic [31:0] hs_wdata [4];
    logic [3:0]  stall = '0;

    always #5 clk = ~clk;

    bb_remap uut (
        .clk(clk), .rst(rst),
        .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
        .up_addr(up_addr), .up_wdata(up_wdata), .up_write(up_write), .up_size(up_size),
        .up_rsp_valid(up_rsp_valid), .up_rdata(up_rdata), .up_rsp_err(up_rsp_err),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_write(dn_write), .dn_size(dn_size),
        .dn_lock(dn_lock), .dn_rsp_valid(dn_rsp_valid), .dn_rdata(dn_rdata), .dn_err(dn_err)
    );

    // downstream model with periodic stalls and error injection
    always @(posedge clk) begin
        dn_rsp_valid <= 1'b0;
        stall        <= stall + 4'd1;
        dn_req_ready <= (stall[1:0] != 2'd1);
        if (!rst && dn_req_valid && dn_req_ready) begin
            int idx;
            idx = {27'd0, dn_addr[29], dn_addr[5:2]};
            if (hs_cnt < 4) begin
                hs_lock[hs_cnt]  = dn_lock;
                hs_write[hs_cnt] = dn_write;
                hs_addr[hs_cnt]  = dn_addr;
                hs_size[hs_cnt]  = dn_size;
                hs_wdata[hs_cnt] = dn_wdata;
            end
            hs_cnt = hs_cnt + 1;
            if (dn_write) begin
                if (idx == err_wr_idx) dn_err <= 1'b1;
                else begin
                    mem[idx] = dn_wdata;
                    dn_err <= 1'b0;
                end
            end else begin
                dn_rdata <= mem[idx];
                dn_err   <= (idx == err_rd_idx);
            end
            dn_rsp_valid <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic [31:0] wd, input logic wr,
                          input logic [1:0] sz, output logic [31:0] rd, output logic er);
        @(negedge clk);
        hs_cnt       = 0;
        up_req_valid = 1'b1;
        up_addr      = a;
        up_wdata     = wd;
        up_write     = wr;
        up_size      = sz;
        while (!up_req_ready) @(negedge clk);
        @(negedge clk);
        up_req_valid = 1'b0;
        while (!up_rsp_valid) @(negedge clk);
        rd = up_rdata;
        er = up_rsp_err;
        @(negedge clk);
    endtask

    function automatic logic [31:0] alias_of(input logic [31:0] ab, input int w, input int b);
        return ab + 32'((w * 4 + b / 8) * 32 + (b % 8) * 4);
    endfunction

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", cycles, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        for (int i = 0; i < 32; i++) begin
            mem[i]     = 32'hA5C3_961E ^ (32'(i) * 32'h0101_0101);
            exp_mem[i] = mem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(up_req_ready && !dn_req_valid && !up_rsp_valid, "R9 reset",
            {29'd0, up_req_ready, dn_req_valid, up_rsp_valid}, 32'h4);

        // R1 pass-through write and read, both regions
        access(32'h4000_0010, 32'hDEAD_BEEF, 1'b1, 2'd2, rd, er);
        exp_mem[4] = 32'hDEAD_BEEF;
        chk(hs_cnt == 1 && !hs_lock[0] && hs_write[0] && hs_addr[0] == 32'h4000_0010,
            "R1 pass write request", hs_addr[0], 32'h4000_0010);
        chk(mem[4] == exp_mem[4] && !er, "R1 pass write data", mem[4], exp_mem[4]);
        access(32'h2000_0030, 32'h0, 1'b0, 2'd2, rd, er);
        chk(rd == exp_mem[16 + 12] && !er, "R1 pass read", rd, exp_mem[28]);
        access(32'h4000_0009, 32'h0000_0077, 1'b1, 2'd0, rd, er);
        exp_mem[2] = 32'h0000_0077;
        chk(hs_size[0] == 2'd0 && hs_addr[0] == 32'h4000_0009 && hs_wdata[0] == 32'h77,
            "R1 pass byte fields", {hs_size[0], hs_addr[0][29:0]}, {2'd0, 30'h0000_0009});
        err_rd_idx = 5;
        access(32'h4000_0014, 32'h0, 1'b0, 2'd2, rd, er);
        chk(er == 1'b1, "R1 pass error", {31'd0, er}, 32'd1);
        err_rd_idx = -1;

        // R2 worked example: 0x42400380 -> word 0x4002001C bit 0
        access(32'h4240_0380, 32'hFFFF_FFFF, 1'b1, 2'd2, rd, er);
        exp_mem[7] = exp_mem[7] | 32'h1;
        chk(hs_addr[0] == 32'h4002_001C && hs_addr[1] == 32'h4002_001C,
            "R2 example address", hs_addr[1], 32'h4002_001C);
        chk(mem[7] == exp_mem[7], "R2 example bit", mem[7], exp_mem[7]);

        // R2 R3 R4 R5 sweep over every bit of four words in both regions
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < 4; w++) begin
                for (int b = 0; b < 32; b++) begin
                    logic [31:0] ab;
                    logic [31:0] tw;
                    logic [31:0] wd;
                    logic        v;
                    int          idx;
                    ab  = (r == 0) ? 32'h4200_0000 : 32'h2200_0000;
                    tw  = ((r == 0) ? 32'h4000_0000 : 32'h2000_0000) + 32'(w * 4);
                    idx = r * 16 + w;
                    v   = (((w * 32 + b) * 7 + r) % 3) != 0;
                    if (exp_mem[idx][b] == v) v = ~v;
                    wd  = (32'h5A5A_5A5A ^ (32'(b) * 32'h0100_0193));
                    wd[0] = v;
                    access(alias_of(ab, w, b), wd, 1'b1, 2'd2, rd, er);
                    exp_mem[idx][b] = v;
                    chk(hs_cnt == 2 && !hs_write[0] && hs_write[1] && hs_lock[0] && hs_lock[1]
                        && hs_size[0] == 2'd2 && hs_size[1] == 2'd2 && !er,
                        "R4 locked read then write", {28'd0, hs_lock[0], hs_lock[1], hs_write[1], er}, 32'he);
                    chk(hs_addr[0] == tw && hs_addr[1] == tw, "R2 target word", hs_addr[1], tw);
                    chk(mem[idx] == exp_mem[idx], "R3 single bit changed", mem[idx], exp_mem[idx]);
                    access(alias_of(ab, w, b), 32'h0, 1'b0, 2'd2, rd, er);
                    chk(rd == {31'd0, v} && hs_cnt == 1 && !hs_lock[0] && !er,
                        "R5 alias read", rd, {31'd0, v});
                end
            end
        end

        // R6 narrow alias accesses
        for (int s = 0; s < 2; s++) begin
            access(alias_of(32'h4200_0000, 1, 9), 32'hFFFF_FFFF, 1'b1, 2'(s), rd, er);
            chk(er && hs_cnt == 0, "R6 narrow alias error", {31'd0, er}, 32'd1);
            chk(mem[1] == exp_mem[1], "R6 target untouched", mem[1], exp_mem[1]);
        end

        // R7 read error on read-modify-write
        err_rd_idx = 3;
        access(alias_of(32'h4200_0000, 3, 17), {31'd0, ~exp_mem[3][17]}, 1'b1, 2'd2, rd, er);
        chk(er && hs_cnt == 1, "R7 read error stops write", {31'd0, er}, 32'd1);
        chk(mem[3] == exp_mem[3], "R7 target untouched", mem[3], exp_mem[3]);
        err_rd_idx = -1;

        // R8 write error on read-modify-write
        err_wr_idx = 16 + 2;
        access(alias_of(32'h2200_0000, 2, 30), {31'd0, ~exp_mem[18][30]}, 1'b1, 2'd2, rd, er);
        chk(er && hs_cnt == 2, "R8 write error returned", {31'd0, er}, 32'd1);
        err_wr_idx = -1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule